// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is a small byte-wide configuration register file for a legacy I/O subsystem. Software reaches it through two I/O addresses: an index port and a data port. The file stays locked until a two-byte key is written to the index port. While it is unlocked, index writes pick one of sixteen 8-bit registers, and data-port accesses read or write that register. A separate exit byte locks the file again.

A handful of register fields are decoded into live configuration outputs:

- the parallel-port base address;
- an auxiliary pair of serial addresses;
- the enable, base address and IRQ of two serial ports;
- a floppy enhanced-mode flag.

The neighbouring controllers use these outputs to place themselves in the I/O map. Every accepted data write also compares the new byte with the old one. For each watched field that actually changed, it raises a one-cycle strobe, so those controllers only reconfigure when they need to.

Top module: `cfg_keyport`

## Requirements
- R1: After reset the registers hold 0x3A (reg 0), 0x9F (reg 1), 0xDC (reg 2), 0x78 (reg 3), 0xFF (reg 6), 0x65 (reg 13) and 0x01 (reg 14), and all others hold 0x00. The key history is cleared and the block is locked.
- R2: The block unlocks only when the last two index-port writes (bus_sel=0) were both 0x55. Any other byte in between breaks the sequence. cfg_active shows the unlocked state.
- R3: While unlocked, an index write of 0xAA enters the key history and locks the block. Unlocking again takes two fresh consecutive 0x55 writes.
- R4: While unlocked, any other index write (0x55 included) selects the register whose number is the low 4 bits of the byte, and the block stays unlocked.
- R5: A data-port read (bus_sel=1) returns the selected register while unlocked. Every other read, including any index-port read, returns 0xFF in the same cycle.
- R6: A data-port write while locked changes no register and raises no strobe.
- R7: par_base decodes reg 1 bits [1:0] as follows: 1 gives 0x3BC, 2 gives 0x378, 3 gives 0x278, and 0 gives 0x000 (disabled).
- R8: Reg 1 bits [6:5] select the auxiliary serial address pair (A/B):
  - 0 gives 0x338/0x238;
  - 1 gives 0x3E8/0x2E8;
  - 2 gives 0x3E8/0x2E0;
  - 3 gives 0x220/0x228.
- R9: Serial port 1 is enabled by reg 2 bit 2, and its source is selected by reg 2 bits [1:0]:
  - 0 gives 0x3F8 with IRQ 4;
  - 1 gives 0x2F8 with IRQ 3;
  - 2 gives pair A with IRQ 4;
  - 3 gives pair B with IRQ 3.
  While disabled, its base and IRQ read 0.
- R10: Serial port 2 is enabled by reg 2 bit 6 and selected by reg 2 bits [5:4], with the same source table as serial port 1. While disabled, its base and IRQ read 0.
- R11: fdc_enh follows reg 3 bit 1.
- R12: chg_strobe bit k pulses for exactly the one cycle after an accepted data write, and only if that write changed watched field k:
  - bit 0 watches reg 1 [1:0];
  - bit 1 watches reg 1 [6:5];
  - bit 2 watches reg 2 [2:0];
  - bit 3 watches reg 2 [6:4];
  - bit 4 watches reg 3 [1].
  Rewriting the same value, or changing only unwatched bits, leaves the strobe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Port select: 0 index, 1 data |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| cfg_active | output | 1 | Unlocked state |
| par_base | output | 12 | Parallel base address, 0 when disabled |
| ser1_en | output | 1 | Serial port 1 enable |
| ser1_base | output | 12 | Serial port 1 base |
| ser1_irq | output | 4 | Serial port 1 IRQ number |
| ser2_en | output | 1 | Serial port 2 enable |
| ser2_base | output | 12 | Serial port 2 base |
| ser2_irq | output | 4 | Serial port 2 IRQ number |
| fdc_enh | output | 1 | Floppy enhanced-mode flag |
| chg_strobe | output | 5 | Per-field change pulses |

## Verification
A key history that has drifted shows up at once on cfg_active. It also shows in the next data read, which returns 0xFF when it should return register contents, or the reverse. A wrong select index reads back the wrong reset default in the same cycle as the read. A register that was corrupted by a write made while locked, or by a write that landed on the wrong register, appears immediately on the decoded address outputs. Where a field has no decoded output, the corruption is seen on the next read-back after unlocking. A stale copy of the old value breaks the change strobes. These are sampled in the cycle after each write, and one cycle later they must be back to zero.

// File: rtl/cfgkp_pkg.sv
`timescale 1ns/1ps
package cfgkp_pkg;
  localparam int DW   = 8;
  localparam int AW   = 12;
  localparam int NFLD = 5;
  localparam int NSER = 2;

  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] ioaddr_t;

  // watched fields: register number and bit mask, in strobe bit order
  localparam int    FLD_REG  [NFLD] = '{1, 1, 2, 2, 3};
  localparam byte_t FLD_MASK [NFLD] = '{8'h03, 8'h60, 8'h07, 8'h70, 8'h02};

  function automatic byte_t reg_default(int idx);
    byte_t v;
    case (idx)
      0:       v = 8'h3A;
      1:       v = 8'h9F;
      2:       v = 8'hDC;
      3:       v = 8'h78;
      6:       v = 8'hFF;
      13:      v = 8'h65;
      14:      v = 8'h01;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic ioaddr_t par_addr(logic [1:0] s);
    ioaddr_t a;
    case (s)
      2'd1:    a = 12'h3BC;
      2'd2:    a = 12'h378;
      2'd3:    a = 12'h278;
      default: a = 12'h000;
    endcase
    return a;
  endfunction

  function automatic ioaddr_t pair_addr(logic [1:0] p, logic second);
    ioaddr_t a;
    case (p)
      2'd0:    a = second ? 12'h238 : 12'h338;
      2'd1:    a = second ? 12'h2E8 : 12'h3E8;
      2'd2:    a = second ? 12'h2E0 : 12'h3E8;
      default: a = second ? 12'h228 : 12'h220;
    endcase
    return a;
  endfunction

  function automatic ioaddr_t ser_addr(logic [1:0] src, logic [1:0] p);
    ioaddr_t a;
    case (src)
      2'd0:    a = 12'h3F8;
      2'd1:    a = 12'h2F8;
      2'd2:    a = pair_addr(p, 1'b0);
      default: a = pair_addr(p, 1'b1);
    endcase
    return a;
  endfunction

  function automatic logic [3:0] ser_irq_of(logic [1:0] src);
    return src[0] ? 4'd3 : 4'd4;
  endfunction
endpackage

// File: rtl/cfgkp_key.sv
`timescale 1ns/1ps
module cfgkp_key
  import cfgkp_pkg::*;
#(
  parameter int    IW      = 4,
  parameter byte_t KEY_ON  = 8'h55,
  parameter byte_t KEY_OFF = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  byte_t         wdata,
  output logic          cfg_mode,
  output logic [IW-1:0] sel
);
  byte_t hist_old_q, hist_new_q;
  logic [IW-1:0] sel_q;
  logic key_shift, sel_load;

  assign cfg_mode  = (hist_old_q == KEY_ON) && (hist_new_q == KEY_ON);
  assign key_shift = idx_wr && (!cfg_mode || wdata == KEY_OFF);
  assign sel_load  = idx_wr && !key_shift;
  assign sel       = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_old_q <= '0;
      hist_new_q <= '0;
      sel_q      <= '0;
    end else if (key_shift) begin
      hist_old_q <= hist_new_q;
      hist_new_q <= wdata;
    end else if (sel_load) begin
      sel_q <= wdata[IW-1:0];
    end
  end

  // R2
  unlock_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> ($past(idx_wr) && $past(wdata) == KEY_ON));
  // R3
  lock_by_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_mode) |-> ($past(idx_wr) && $past(wdata) == KEY_OFF));
  // R4
  select_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && cfg_mode && wdata != KEY_OFF) |=> cfg_mode);
endmodule

// File: rtl/cfgkp_regs.sv
`timescale 1ns/1ps
module cfgkp_regs
  import cfgkp_pkg::*;
#(
  parameter int NREG = 16,
  parameter int IW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      sel,
  input  byte_t              wdata,
  output byte_t              rd_val,
  output logic [NREG*DW-1:0] flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    byte_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= reg_default(i);
      else if (wr_en && sel == IW'(i))     q <= wdata;
    end
    assign flat[i*DW +: DW] = q;
  end

  assign rd_val = flat[int'(sel)*DW +: DW];
endmodule

// File: rtl/cfgkp_watch.sv
`timescale 1ns/1ps
module cfgkp_watch
  import cfgkp_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   sel,
  input  byte_t           old_val,
  input  byte_t           new_val,
  output logic [NFLD-1:0] chg_strobe
);
  logic [NFLD-1:0] hit;

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    assign hit[f] = wr_en && (int'(sel) == FLD_REG[f]) &&
                    (|((old_val ^ new_val) & FLD_MASK[f]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_strobe <= '0;
    else        chg_strobe <= hit;
  end

  // R12
  strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_strobe != '0) |-> $past(wr_en));
endmodule

// File: rtl/cfgkp_decode.sv
`timescale 1ns/1ps
module cfgkp_decode
  import cfgkp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      par_sel,
  input  logic [1:0]      pair_sel,
  input  logic [2:0]      ser_cfg [NSER],
  input  logic            fdc_bit,
  output ioaddr_t         par_base,
  output logic [NSER-1:0] ser_en,
  output ioaddr_t         ser_base [NSER],
  output logic [3:0]      ser_irq  [NSER],
  output logic            fdc_enh
);
  assign par_base = par_addr(par_sel);
  assign fdc_enh  = fdc_bit;

  for (genvar k = 0; k < NSER; k++) begin : g_ser
    assign ser_en[k]   = ser_cfg[k][2];
    assign ser_base[k] = ser_cfg[k][2] ? ser_addr(ser_cfg[k][1:0], pair_sel) : '0;
    assign ser_irq[k]  = ser_cfg[k][2] ? ser_irq_of(ser_cfg[k][1:0]) : 4'd0;

    // R9 R10
    irq_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_en[k] |-> (ser_irq[k] == 4'd3 || ser_irq[k] == 4'd4));
  end
endmodule

// File: rtl/cfg_keyport.sv
`timescale 1ns/1ps
module cfg_keyport
  import cfgkp_pkg::*;
#(
  parameter int    NREG    = 16,
  parameter byte_t KEY_ON  = 8'h55,
  parameter byte_t KEY_OFF = 8'hAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        cfg_active,
  output logic [11:0] par_base,
  output logic        ser1_en,
  output logic [11:0] ser1_base,
  output logic [3:0]  ser1_irq,
  output logic        ser2_en,
  output logic [11:0] ser2_base,
  output logic [3:0]  ser2_irq,
  output logic        fdc_enh,
  output logic [4:0]  chg_strobe
);
  localparam int IW      = $clog2(NREG);
  localparam int REG_MAP = 1;
  localparam int REG_SER = 2;
  localparam int REG_FDC = 3;

  logic            cfg_mode;
  logic [IW-1:0]   sel;
  logic            idx_wr, data_wr;
  byte_t           rd_val;
  logic [NREG*DW-1:0] reg_flat;
  logic [2:0]      ser_cfg  [NSER];
  logic [NSER-1:0] ser_en;
  ioaddr_t         ser_base [NSER];
  logic [3:0]      ser_irq  [NSER];

  assign idx_wr  = bus_wr && !bus_sel;
  assign data_wr = bus_wr &&  bus_sel && cfg_mode;

  cfgkp_key #(.IW(IW), .KEY_ON(KEY_ON), .KEY_OFF(KEY_OFF)) u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(bus_wdata),
    .cfg_mode(cfg_mode), .sel(sel));

  cfgkp_regs #(.NREG(NREG), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .sel(sel), .wdata(bus_wdata),
    .rd_val(rd_val), .flat(reg_flat));

  cfgkp_watch #(.IW(IW)) u_watch (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .sel(sel),
    .old_val(rd_val), .new_val(bus_wdata), .chg_strobe(chg_strobe));

  assign ser_cfg[0] = reg_flat[REG_SER*DW     +: 3];
  assign ser_cfg[1] = reg_flat[REG_SER*DW + 4 +: 3];

  cfgkp_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .par_sel(reg_flat[REG_MAP*DW +: 2]),
    .pair_sel(reg_flat[REG_MAP*DW + 5 +: 2]),
    .ser_cfg(ser_cfg),
    .fdc_bit(reg_flat[REG_FDC*DW + 1]),
    .par_base(par_base), .ser_en(ser_en), .ser_base(ser_base),
    .ser_irq(ser_irq), .fdc_enh(fdc_enh));

  assign cfg_active = cfg_mode;
  assign bus_rdata  = (bus_rd && bus_sel && cfg_mode) ? rd_val : 8'hFF;
  assign ser1_en    = ser_en[0];
  assign ser1_base  = ser_base[0];
  assign ser1_irq   = ser_irq[0];
  assign ser2_en    = ser_en[1];
  assign ser2_base  = ser_base[1];
  assign ser2_irq   = ser_irq[1];

  // R6
  regs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(reg_flat));
endmodule

// File: tb/tb_cfg_keyport.sv
`timescale 1ns/1ps
module tb_cfg_keyport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        cfg_active, ser1_en, ser2_en, fdc_enh;
  logic [11:0] par_base, ser1_base, ser2_base;
  logic [3:0]  ser1_irq, ser2_irq;
  logic [4:0]  chg_strobe;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  cfg_keyport dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_active(cfg_active),
    .par_base(par_base), .ser1_en(ser1_en), .ser1_base(ser1_base), .ser1_irq(ser1_irq),
    .ser2_en(ser2_en), .ser2_base(ser2_base), .ser2_irq(ser2_irq),
    .fdc_enh(fdc_enh), .chg_strobe(chg_strobe));

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for reads
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, int'(bus_rdata), int'(e));
    end
  end

  task automatic wr(logic s, logic [7:0] v);
    @(posedge clk); #1;
    bus_sel = s; bus_wdata = v; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic s, logic [7:0] e, string tag);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_sel = s; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic strobe_chk(logic [4:0] e, string tag);
    @(negedge clk);
    chk(tag, int'(chg_strobe), int'(e));
    @(negedge clk);
    chk({tag, " clear"}, int'(chg_strobe), 0);
  endtask

  task automatic ser_chk(int k, logic en, int base, int irq, string tag);
    if (k == 1) begin
      chk({tag, " en1"}, int'(ser1_en), int'(en));
      chk({tag, " base1"}, int'(ser1_base), base);
      chk({tag, " irq1"}, int'(ser1_irq), irq);
    end else begin
      chk({tag, " en2"}, int'(ser2_en), int'(en));
      chk({tag, " base2"}, int'(ser2_base), base);
      chk({tag, " irq2"}, int'(ser2_irq), irq);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state through decoded outputs
    chk("R1 locked", int'(cfg_active), 0);
    chk("R1 R7 par default", int'(par_base), 'h278);
    ser_chk(1, 1'b1, 'h3F8, 4, "R1 R9 default");
    ser_chk(2, 1'b1, 'h2F8, 3, "R1 R10 default");
    chk("R1 R11 fdc default", int'(fdc_enh), 0);
    chk("R1 strobe idle", int'(chg_strobe), 0);
    // R5 locked reads
    rd(1'b1, 8'hFF, "R5 data read locked");
    rd(1'b0, 8'hFF, "R5 index read");
    // R6 locked data write ignored
    wr(1'b1, 8'h00);
    strobe_chk(5'b0, "R6 no strobe locked");
    chk("R6 par unchanged", int'(par_base), 'h278);
    // R2 broken key
    wr(1'b0, 8'h55); wr(1'b0, 8'h00); wr(1'b0, 8'h55);
    @(negedge clk); chk("R2 broken key stays locked", int'(cfg_active), 0);
    rd(1'b1, 8'hFF, "R2 broken key read");
    wr(1'b0, 8'h55);
    @(negedge clk); chk("R2 unlocked", int'(cfg_active), 1);
    // R1 R4 defaults readback
    wr(1'b0, 8'h00); rd(1'b1, 8'h3A, "R1 reg0");
    wr(1'b0, 8'h21); rd(1'b1, 8'h9F, "R4 R1 reg1 low nibble");
    wr(1'b0, 8'h02); rd(1'b1, 8'hDC, "R1 reg2");
    wr(1'b0, 8'h03); rd(1'b1, 8'h78, "R1 reg3");
    wr(1'b0, 8'h06); rd(1'b1, 8'hFF, "R1 reg6");
    wr(1'b0, 8'h0D); rd(1'b1, 8'h65, "R1 reg13");
    wr(1'b0, 8'hFE); rd(1'b1, 8'h01, "R4 R1 reg14");
    wr(1'b0, 8'h04); rd(1'b1, 8'h00, "R1 reg4");
    wr(1'b0, 8'h0F); rd(1'b1, 8'h00, "R1 reg15");
    // R7 R12 parallel field
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h9D); strobe_chk(5'b00001, "R12 par change");
    chk("R7 par 3BC", int'(par_base), 'h3BC);
    wr(1'b1, 8'h9D); strobe_chk(5'b00000, "R12 same value");
    wr(1'b1, 8'h22); strobe_chk(5'b00011, "R12 par+pair");
    chk("R7 par 378", int'(par_base), 'h378);
    wr(1'b1, 8'h40); strobe_chk(5'b00011, "R12 par+pair 2");
    chk("R7 par disabled", int'(par_base), 0);
    wr(1'b1, 8'h63); strobe_chk(5'b00011, "R12 par+pair 3");
    chk("R7 par 278", int'(par_base), 'h278);
    // R9 R10 serial via pair 3
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h06); strobe_chk(5'b01100, "R12 serial fields");
    ser_chk(1, 1'b1, 'h220, 4, "R9 R8 src2 pair3");
    ser_chk(2, 1'b0, 0, 0, "R10 disabled");
    wr(1'b1, 8'h77); strobe_chk(5'b01100, "R12 serial fields 2");
    ser_chk(1, 1'b1, 'h228, 3, "R9 R8 src3 pair3");
    ser_chk(2, 1'b1, 'h228, 3, "R10 R8 src3 pair3");
    // R8 other pairs
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h43); strobe_chk(5'b00010, "R12 pair only");
    ser_chk(1, 1'b1, 'h2E0, 3, "R8 pair2 B");
    wr(1'b1, 8'h23); strobe_chk(5'b00010, "R12 pair only 2");
    ser_chk(1, 1'b1, 'h2E8, 3, "R8 pair1 B");
    wr(1'b1, 8'h03); strobe_chk(5'b00010, "R12 pair only 3");
    ser_chk(1, 1'b1, 'h238, 3, "R8 pair0 B");
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h25); strobe_chk(5'b01100, "R12 serial fields 3");
    ser_chk(1, 1'b1, 'h2F8, 3, "R9 src1");
    ser_chk(2, 1'b0, 0, 0, "R10 disabled 2");
    wr(1'b1, 8'h61); strobe_chk(5'b01100, "R12 serial fields 4");
    ser_chk(1, 1'b0, 0, 0, "R9 disabled");
    ser_chk(2, 1'b1, 'h338, 4, "R10 R8 src2 pair0");
    // R11
    wr(1'b0, 8'h03);
    wr(1'b1, 8'h7A); strobe_chk(5'b10000, "R12 fdc field");
    chk("R11 fdc set", int'(fdc_enh), 1);
    wr(1'b1, 8'h7B); strobe_chk(5'b00000, "R12 unwatched bit");
    chk("R11 fdc held", int'(fdc_enh), 1);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hFF); strobe_chk(5'b00000, "R12 unwatched reg");
    wr(1'b0, 8'h01); rd(1'b1, 8'h03, "R4 reg1 readback");
    // R4 key byte as select
    wr(1'b0, 8'h55);
    @(negedge clk); chk("R4 stays unlocked", int'(cfg_active), 1);
    rd(1'b1, 8'h00, "R4 0x55 selects reg5");
    // R3 exit
    wr(1'b0, 8'hAA);
    @(negedge clk); chk("R3 locked", int'(cfg_active), 0);
    rd(1'b1, 8'hFF, "R3 read after exit");
    wr(1'b1, 8'h00);
    strobe_chk(5'b00000, "R6 no strobe after exit");
    ser_chk(2, 1'b1, 'h338, 4, "R6 ignored write");
    wr(1'b0, 8'h55);
    @(negedge clk); chk("R3 one key not enough", int'(cfg_active), 0);
    wr(1'b0, 8'h55);
    @(negedge clk); chk("R3 relock entry", int'(cfg_active), 1);
    wr(1'b0, 8'h02); rd(1'b1, 8'h61, "R6 reg2 untouched");
    repeat (2) @(posedge clk);
    done = 1'b1;
    summary();
  end
endmodule